// File: doc/BRIEF.md
# Two-Level Short-Descriptor Page Table Walker

This block translates a 32-bit virtual address into a physical address by fetching descriptors from an in-memory, two-level page table. A consumer hands it a virtual address together with a table base value. The walker reads one first-level descriptor and decodes it. Depending on that entry, it either finishes or fetches one second-level descriptor. It then presents a single result: the physical address, mapping size, a 3-bit permission code, a 4-bit domain, the execute-never flag, the global flag and a fault code.

Mappings come in three sizes. A first-level entry may map 1 MB directly. It may instead point to a second-level table whose entries map 64 KB or 4 KB. A second-level result takes its domain from its parent entry. Only one walk is in flight at a time. The walker holds its result steady until the consumer takes it.

The memory side uses a valid/ready request channel that carries the descriptor address. Read data comes back as a one-cycle beat, which the walker always accepts while it waits.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, reqReady is 1 while memReqValid and rspValid are 0.
- R2: The first read goes to address {ttb[31:14], va[31:20], 2'b00}. memReqValid stays high with memAddr unchanged until memReqReady is seen.
- R3: A first-level descriptor with bits [1:0] equal to 00 or 11 ends the walk after one read with fault code 1. Code 2'b01 selects a table. Code 2'b10 selects a 1 MB section.
- R4: For a section, rspPa = {d[31:20], va[19:0]} and rspSize = 0. rspAp = {d[15], d[11:10]}, rspXn = d[4], rspGlobal = !d[17] and rspDomain = d[8:5].
- R5: A section whose bit 18 is set is an unsupported case. It ends the walk after one read with fault code 3.
- R6: For a table entry, a second read goes to address {d1[31:10], va[19:12], 2'b00}.
- R7: A second-level descriptor with bits [1:0] equal to 00 gives fault code 2.
- R8: A second-level descriptor with bit 1 clear and bit 0 set is a 64 KB page. For it, rspPa = {d2[31:16], va[15:0]}, rspXn = d2[15] and rspSize = 1.
- R9: A second-level descriptor with bit 1 set is a 4 KB page. For it, rspPa = {d2[31:12], va[11:0]}, rspXn = d2[0] and rspSize = 2.
- R10: For second-level results, rspAp = {d2[9], d2[5:4]} and rspGlobal = !d2[11]. rspDomain comes from bits [8:5] of the first-level entry.
- R11: A request is taken only when idle (reqReady is 0 during a walk). rspValid and every result field stay constant until rspReady is seen.
- R12: When the fault code is non-zero, rspPa, rspAp, rspDomain, rspXn, rspGlobal and rspSize are all 0.
- R13: memReqValid rises in the cycle after acceptance, and the second request in the cycle after the first data beat. rspValid rises in the cycle after the last data beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle, request taken |
| reqVa | input | 32 | Virtual address |
| reqTtb | input | 32 | Table base value (bits 31:14 used) |
| memReqValid | output | 1 | Descriptor read request |
| memReqReady | input | 1 | Memory takes the request |
| memAddr | output | 32 | Descriptor address |
| memRspValid | input | 1 | Read data beat |
| memRspData | input | 32 | Descriptor word |
| rspValid | output | 1 | Result available |
| rspReady | input | 1 | Consumer takes the result |
| rspPa | output | 32 | Physical address |
| rspAp | output | 3 | Access permission code |
| rspDomain | output | 4 | Domain |
| rspXn | output | 1 | Execute-never |
| rspGlobal | output | 1 | Global mapping |
| rspFault | output | 2 | 0 none, 1 first-level, 2 second-level, 3 unsupported |
| rspSize | output | 2 | 0 1 MB, 1 64 KB, 2 4 KB |

## Verification
Say a request is taken at an edge, each read waits S stall cycles on memReqReady, and the walk needs N reads. The result then becomes visible 2N + N·S + 1 cycle-counter steps after that edge: one step per request, one per data beat, and one to enter the result state. The bench stores this figure with every expected item and measures the step at which rspValid is first sampled against it. It also checks each descriptor address when its handshake happens, and counts the reads in each walk. While it holds off rspReady, it compares every result field with the values it saw first.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int VA_W   = 32;
  localparam int DESC_W = 32;
  localparam int AP_W   = 3;
  localparam int DOM_W  = 4;
  localparam int SECT_SH = 20;
  localparam int LARGE_SH = 16;
  localparam int SMALL_SH = 12;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_L1    = 2'd1,
    FLT_L2    = 2'd2,
    FLT_SUPER = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    SZ_SECTION = 2'd0,
    SZ_LARGE   = 2'd1,
    SZ_SMALL   = 2'd2
  } size_e;

  localparam logic [1:0] L1_TABLE   = 2'b01;
  localparam logic [1:0] L1_SECTION = 2'b10;

  typedef struct packed {
    logic capReq;
    logic capL1;
    logic capL2;
    logic selL2;
  } walkStrobe_t;
endpackage

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        memReqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic [1:0]  beatKind,
  input  logic        beatSuper,
  output logic        rspValid,
  input  logic        rspReady,
  output fault_e      faultQ,
  output walkStrobe_t strobe
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_L1RD, ST_L1WT, ST_L2RD, ST_L2WT, ST_DONE
  } state_e;

  state_e stateQ, stateN;
  fault_e faultN;
  logic   lvl2Q, lvl2N;

  always_comb begin
    stateN = stateQ;
    faultN = faultQ;
    lvl2N  = lvl2Q;
    strobe = '0;
    strobe.selL2 = lvl2Q;
    unique case (stateQ)
      ST_IDLE: if (reqValid) begin
        strobe.capReq = 1'b1;
        faultN = FLT_NONE;
        lvl2N  = 1'b0;
        stateN = ST_L1RD;
      end
      ST_L1RD: if (memReqReady) stateN = ST_L1WT;
      ST_L1WT: if (memRspValid) begin
        strobe.capL1 = 1'b1;
        if (beatKind == L1_TABLE) begin
          lvl2N  = 1'b1;
          stateN = ST_L2RD;
        end else if (beatKind == L1_SECTION) begin
          faultN = beatSuper ? FLT_SUPER : FLT_NONE;
          stateN = ST_DONE;
        end else begin
          faultN = FLT_L1;
          stateN = ST_DONE;
        end
      end
      ST_L2RD: if (memReqReady) stateN = ST_L2WT;
      ST_L2WT: if (memRspValid) begin
        strobe.capL2 = 1'b1;
        faultN = (beatKind == 2'b00) ? FLT_L2 : FLT_NONE;
        stateN = ST_DONE;
      end
      ST_DONE: if (rspReady) stateN = ST_IDLE;
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      faultQ <= FLT_NONE;
      lvl2Q  <= 1'b0;
    end else begin
      stateQ <= stateN;
      faultQ <= faultN;
      lvl2Q  <= lvl2N;
    end
  end

  assign reqReady    = (stateQ == ST_IDLE);
  assign memReqValid = (stateQ == ST_L1RD) || (stateQ == ST_L2RD);
  assign rspValid    = (stateQ == ST_DONE);

  AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid); // R2
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(faultQ)); // R11
  AST_START_READ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> memReqValid && !reqReady); // R13
  AST_SECOND_READ: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capL1 && beatKind == L1_TABLE |=> memReqValid); // R6
endmodule

// File: rtl/pgwalk_dpath.sv
module pgwalk_dpath
  import pgwalk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  fault_e            fault,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [VA_W-1:0]   reqTtb,
  input  logic [DESC_W-1:0] memRspData,
  output logic [1:0]        beatKind,
  output logic              beatSuper,
  output logic [VA_W-1:0]   memAddr,
  output logic [VA_W-1:0]   rspPa,
  output logic [AP_W-1:0]   rspAp,
  output logic [DOM_W-1:0]  rspDomain,
  output logic              rspXn,
  output logic              rspGlobal,
  output logic [1:0]        rspSize
);
  localparam int TTB_LO = 14;

  logic [VA_W-1:0]   vaQ;
  logic [VA_W-1:TTB_LO] ttbQ;
  logic [DESC_W-1:0] d1Q, d2Q;
  logic              unusedBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ  <= '0;
      ttbQ <= '0;
      d1Q  <= '0;
      d2Q  <= '0;
    end else begin
      if (strobe.capReq) begin
        vaQ  <= reqVa;
        ttbQ <= reqTtb[VA_W-1:TTB_LO];
      end
      if (strobe.capL1) d1Q <= memRspData;
      if (strobe.capL2) d2Q <= memRspData;
    end
  end

  assign beatKind  = memRspData[1:0];
  assign beatSuper = memRspData[18];

  assign memAddr = strobe.selL2 ? {d1Q[31:10], vaQ[19:12], 2'b00}
                                : {ttbQ, vaQ[31:20], 2'b00};

  always_comb begin
    rspPa = '0; rspAp = '0; rspDomain = '0;
    rspXn = 1'b0; rspGlobal = 1'b0; rspSize = SZ_SECTION;
    if (fault == FLT_NONE) begin
      rspDomain = d1Q[8:5];
      if (!strobe.selL2) begin
        rspPa     = {d1Q[31:SECT_SH], vaQ[SECT_SH-1:0]};
        rspAp     = {d1Q[15], d1Q[11:10]};
        rspXn     = d1Q[4];
        rspGlobal = !d1Q[17];
        rspSize   = SZ_SECTION;
      end else begin
        rspAp     = {d2Q[9], d2Q[5:4]};
        rspGlobal = !d2Q[11];
        if (d2Q[1]) begin
          rspPa   = {d2Q[31:SMALL_SH], vaQ[SMALL_SH-1:0]};
          rspXn   = d2Q[0];
          rspSize = SZ_SMALL;
        end else begin
          rspPa   = {d2Q[31:LARGE_SH], vaQ[LARGE_SH-1:0]};
          rspXn   = d2Q[15];
          rspSize = SZ_LARGE;
        end
      end
    end
  end

  assign unusedBits = ^{d1Q[19:18], d1Q[16], d1Q[9], d1Q[3:0],
                        d2Q[10], d2Q[8:6], d2Q[3:2]};
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [VA_W-1:0]   reqTtb,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [VA_W-1:0]   memAddr,
  input  logic              memRspValid,
  input  logic [DESC_W-1:0] memRspData,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [VA_W-1:0]   rspPa,
  output logic [AP_W-1:0]   rspAp,
  output logic [DOM_W-1:0]  rspDomain,
  output logic              rspXn,
  output logic              rspGlobal,
  output logic [1:0]        rspFault,
  output logic [1:0]        rspSize
);
  walkStrobe_t strobe;
  fault_e      faultQ;
  logic [1:0]  beatKind;
  logic        beatSuper;

  pgwalk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .beatKind(beatKind), .beatSuper(beatSuper),
    .rspValid(rspValid), .rspReady(rspReady), .faultQ(faultQ), .strobe(strobe)
  );

  pgwalk_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fault(faultQ),
    .reqVa(reqVa), .reqTtb(reqTtb), .memRspData(memRspData),
    .beatKind(beatKind), .beatSuper(beatSuper), .memAddr(memAddr),
    .rspPa(rspPa), .rspAp(rspAp), .rspDomain(rspDomain), .rspXn(rspXn),
    .rspGlobal(rspGlobal), .rspSize(rspSize)
  );

  assign rspFault = faultQ;

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memAddr)); // R2
  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> $stable(rspPa) && $stable(rspAp) && $stable(rspDomain)); // R11
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault != 2'd0 |-> rspPa == '0 && rspAp == '0 && rspDomain == '0
    && !rspXn && !rspGlobal && rspSize == 2'd0); // R12
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady && !memReqValid); // R11
endmodule

// File: tb/pgwalk_top_bench.sv
module pgwalk_top_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [31:0] reqVa = '0, reqTtb = '0;
  logic memReqValid, memReqReady = 1'b0;
  logic [31:0] memAddr;
  logic memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic rspValid, rspReady = 1'b0;
  logic [31:0] rspPa;
  logic [2:0] rspAp;
  logic [3:0] rspDomain;
  logic rspXn, rspGlobal;
  logic [1:0] rspFault, rspSize;

  always #2.5 clk = ~clk;

  pgwalk_top u_pgwalk_top (.*);

  typedef struct packed {
    logic [31:0] pa; logic [2:0] ap; logic [3:0] dom; logic xn; logic gl;
    logic [1:0] fault; logic [1:0] size; logic [1:0] reads;
    logic [31:0] a1; logic [31:0] a2; logic [3:0] stall;
  } exp_t;

  logic [31:0] mem [bit [31:0]];
  exp_t q[$];
  int checks = 0, failures = 0, cyc = 0, acceptCyc = 0, rdCnt = 0;
  int stallSet = 0, holdSet = 0, stallLeft = 0;
  logic pendingRsp = 1'b0;
  logic [31:0] pendData = '0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic exp_t model(input logic [31:0] va, input logic [31:0] ttb);
    exp_t e; logic [31:0] d1, d2;
    e = '0;
    e.a1 = {ttb[31:14], va[31:20], 2'b00};
    d1 = rd(e.a1); e.reads = 2'd1;
    if (d1[1:0] == 2'b00 || d1[1:0] == 2'b11) e.fault = 2'd1;        // R3
    else if (d1[1:0] == 2'b10) begin
      if (d1[18]) e.fault = 2'd3;                                     // R5
      else begin                                                      // R4
        e.pa = {d1[31:20], va[19:0]}; e.ap = {d1[15], d1[11:10]};
        e.xn = d1[4]; e.gl = !d1[17]; e.dom = d1[8:5]; e.size = 2'd0;
      end
    end else begin
      e.a2 = {d1[31:10], va[19:12], 2'b00}; e.reads = 2'd2;           // R6
      d2 = rd(e.a2);
      if (d2[1:0] == 2'b00) e.fault = 2'd2;                           // R7
      else begin                                                      // R10
        e.ap = {d2[9], d2[5:4]}; e.gl = !d2[11]; e.dom = d1[8:5];
        if (d2[1]) begin e.pa = {d2[31:12], va[11:0]}; e.xn = d2[0]; e.size = 2'd2; end  // R9
        else begin e.pa = {d2[31:16], va[15:0]}; e.xn = d2[15]; e.size = 2'd1; end        // R8
      end
    end
    return e;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // memory model
  always @(posedge clk) begin
    if (rstN && memReqValid && memReqReady) begin
      if (q.size() != 0) begin
        if (rdCnt == 0) check(memAddr == q[0].a1, "R2", "first read address", memAddr, q[0].a1);
        else check(memAddr == q[0].a2, "R6", "second read address", memAddr, q[0].a2);
      end
      rdCnt++;
      pendingRsp = 1'b1;
      pendData = rd(memAddr);
      stallLeft = stallSet;
    end
  end

  always @(negedge clk) begin
    memRspValid = pendingRsp;
    memRspData  = pendingRsp ? pendData : 32'h0;
    pendingRsp  = 1'b0;
    if (memReqValid && stallLeft > 0) begin
      memReqReady = 1'b0; stallLeft--;
    end else memReqReady = 1'b1;
  end

  // monitor
  bit seen = 0;
  int holdLeft = 0;
  logic [47:0] snap;
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      exp_t e;
      logic [47:0] now;
      now = {rspPa, rspAp, rspDomain, rspXn, rspGlobal, rspFault, rspSize, 4'h0};
      check(!reqReady, "R11", "reqReady while result pending", {31'd0, reqReady}, 32'd0);
      if (!seen) begin
        seen = 1; snap = now; holdLeft = holdSet;
        if (q.size() != 0) begin
          int lat;
          lat = cyc - acceptCyc;
          check(lat == 2*q[0].reads + 1 + q[0].reads*q[0].stall, "R13", "result latency",
                lat, 2*q[0].reads + 1 + q[0].reads*q[0].stall);
        end
      end
      if (holdLeft > 0) begin
        check(now == snap, "R11", "result held stable", now[47:16], snap[47:16]);
        holdLeft--; rspReady = 1'b0;
      end else if (q.size() != 0) begin
        e = q.pop_front();
        check(rspFault == e.fault, "R3/R5/R7", "fault code", rspFault, e.fault);
        check(rdCnt == e.reads, "R3", "read count", rdCnt, e.reads);
        check(rspPa == e.pa, "R4/R8/R9/R12", "pa", rspPa, e.pa);
        check(rspSize == e.size, "R8/R9/R12", "size", rspSize, e.size);
        check({rspAp, rspXn, rspGlobal} == {e.ap, e.xn, e.gl}, "R4/R10/R12", "ap/xn/global",
              {rspAp, rspXn, rspGlobal}, {e.ap, e.xn, e.gl});
        check(rspDomain == e.dom, "R10", "domain", rspDomain, e.dom);
        rspReady = 1'b1; seen = 0;
      end else begin
        check(0, "R11", "unexpected result", 1, 0);
        rspReady = 1'b1; seen = 0;
      end
    end else rspReady = 1'b0;
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] ttb,
                      input int stall, input int hold, input bit noWait);
    exp_t e;
    if (!noWait) wait (q.size() == 0 && !rspValid);
    @(negedge clk);
    stallSet = stall; holdSet = hold;
    reqValid = 1'b1; reqVa = va; reqTtb = ttb;
    forever begin
      @(posedge clk);
      if (reqReady) break;
    end
    e = model(va, ttb);
    e.stall = 4'(stall);
    q.push_back(e);
    rdCnt = 0; acceptCyc = cyc; stallLeft = stall;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  function automatic logic [31:0] l1a(input logic [31:0] va, input logic [31:0] ttb);
    return {ttb[31:14], va[31:20], 2'b00};
  endfunction

  localparam logic [31:0] TTB = 32'h0004_3ABC;   // low 14 bits must be ignored (R2)
  localparam logic [31:0] L2B = 32'h0010_0400;

  initial begin
    // descriptor image
    mem[l1a(32'h0010_2345, TTB)] = 32'hABC0_0000 | (1<<15) | (2'b01<<10) | (5<<5) | (1<<4) | 2'b10;
    mem[l1a(32'h0027_7777, TTB)] = 32'h1230_0000 | (1<<17) | (2'b10<<10) | (9<<5) | 2'b10;
    mem[l1a(32'h0030_0000, TTB)] = 32'h5550_0000 | (1<<18) | 2'b10;
    mem[l1a(32'h0040_0000, TTB)] = 32'hFFFF_FFFC;
    mem[l1a(32'h0050_0000, TTB)] = 32'h7770_0003;
    mem[l1a(32'h0060_0000, TTB)] = L2B | (4'hC<<5) | 2'b01;
    mem[{L2B[31:10], 8'h12, 2'b00}] = 32'h8765_4000 | (1<<11) | (1<<9) | (2'b10<<4) | 2'b11;
    mem[{L2B[31:10], 8'h34, 2'b00}] = 32'h4321_0000 | (1<<15) | (2'b01<<4) | 2'b01;
    mem[{L2B[31:10], 8'h56, 2'b00}] = 32'hDEAD_BEEC;
    mem[{L2B[31:10], 8'h78, 2'b00}] = 32'h0246_8000 | (1<<10) | (2'b11<<4) | 2'b10;
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "R1", "reqReady in reset", reqReady, 1);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !memReqValid && !rspValid, "R1", "idle after reset",
          {reqReady, memReqValid, rspValid}, 3'b100);
    walk(32'h0010_2345, TTB, 0, 0, 0);                 // R4 section
    walk(32'h0027_7777, TTB, 0, 0, 0);                 // R4 non-global
    walk(32'h0030_0000, TTB, 0, 0, 0);                 // R5 unsupported
    walk(32'h0040_0000, TTB, 0, 0, 0);                 // R3 type 00
    walk(32'h0050_0000, TTB, 0, 0, 0);                 // R3 type 11
    walk(32'h0061_2ABC, TTB, 0, 0, 0);                 // R9 small
    walk(32'h0063_4DEF, TTB, 0, 0, 0);                 // R8 large
    walk(32'h0065_6000, TTB, 0, 0, 0);                 // R7 invalid L2
    walk(32'h0067_8FFF, TTB, 0, 0, 0);                 // R9 xn clear
    walk(32'h0010_FFFF, TTB, 2, 3, 0);                 // R2/R11 stalls and hold
    walk(32'h0061_2001, TTB, 1, 2, 0);                 // R13 stall on both reads
    walk(32'h0063_4000, TTB, 0, 1, 0);                 // R11 back-to-back
    walk(32'h0027_0001, TTB, 0, 0, 1);
    wait (q.size() == 0 && !rspValid);
    repeat (4) @(negedge clk);
    check(reqReady && !rspValid, "R11", "idle at end", {reqReady, rspValid}, 2'b10);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL R13 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule